// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Responder

This block is the device side of a three-wire serial EEPROM link. A host toggles chip select, serial clock and data-in by software or by a simple sequencer. The block decodes the serial command and answers on a single data-out line. All four serial signals are sampled by the block's system clock. A falling serial clock edge counts only when the system clock has seen the serial clock high in the previous cycle and low in the current one.

A transaction opens when chip select goes high. It carries a start bit, a two-bit command and an address whose width comes from a configuration input. After the address, the block either returns a sixteen-bit word from its internal register array, or it gathers a sixteen-bit word that it stores when chip select goes low. A side load port fills the array with its initial contents. Dropping chip select at any time ends the transaction.

Top module: `mw_eeprom_resp`

## Requirements
- R1: `dout` is 1 after reset, and it is 1 in the cycle after any cycle in which `cs` is low.
- R2: `di` is taken only on a falling `sk` edge while `cs` is high. Rising edges, and `sk` activity while `cs` is low, change nothing.
- R3: Samples of 0 taken before the first sample of 1 are ignored. The first 1 is the start bit.
- R4: The two samples after the start bit form the command, first sample in the upper bit. 2'b10 means read and 2'b01 means write.
- R5: After the command, exactly `addrLen` samples form the word address, most significant bit first. The values used are 6 and 8.
- R6: `dout` becomes 0 in the cycle after the falling edge that delivers the last address bit.
- R7: During a read, each later falling edge puts the next bit of the addressed word on `dout`, bit 15 first, while `di` is ignored. After all 16 bits, `dout` stays 0.
- R8: During a write, the samples after the address are shifted into a 16-bit word, and the last 16 samples are kept. The word is stored at the address only when `cs` goes low.
- R9: `cs` going low before the data phase ends the transaction and stores nothing. The next transaction starts fresh from its start bit.
- R10: The commands 2'b00 and 2'b11 are not acted on. `dout` stays 1 and nothing is stored until `cs` goes low.
- R11: A cycle with `loadEn` high writes `loadData` to entry `loadAddr`. A later read returns that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select from the host, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| addrLen | input | 4 | Address length in bits, from 1 to ADDR_W |
| loadEn | input | 1 | Array load strobe |
| loadAddr | input | 8 | Array load index |
| loadData | input | 16 | Array load word |
| dout | output | 1 | Serial data to the host |

## Verification
Every serial result is registered once. The dummy zero, each read data bit and the return to 1 after `cs` drops all appear on `dout` one system clock after the cycle in which the falling edge or the low `cs` is first seen. A stored write becomes visible only through a later read transaction. The bench changes its inputs on the falling system clock edge and updates its behavioural model in the same step. At the next falling edge, after exactly one rising edge, it compares `dout` against that model, so every cycle is checked at the point where its result is due.

// File: rtl/mw_eeprom_pkg.sv
`timescale 1ns/1ps
package mw_eeprom_pkg;

  localparam logic [1:0] CMD_READ  = 2'b10;
  localparam logic [1:0] CMD_WRITE = 2'b01;

  typedef enum logic [2:0] {
    PH_WAIT  = 3'd0,
    PH_CMD   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_RDATA = 3'd3,
    PH_WDATA = 3'd4,
    PH_SKIP  = 3'd5
  } phase_t;

  typedef struct packed {
    logic clear;
    logic addrShift;
    logic addrDone;
    logic fetch;
    logic rdShift;
    logic wrShift;
    logic commit;
  } ctlStrobes_t;

endpackage

// File: rtl/mw_eeprom_ctrl.sv
`timescale 1ns/1ps
module mw_eeprom_ctrl
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int LEN_W = $clog2(ADDR_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cs,
  input  logic             sk,
  input  logic             di,
  input  logic [LEN_W-1:0] addrLen,
  output ctlStrobes_t      strobes
);

  phase_t           phase;
  logic [LEN_W-1:0] bitCnt;
  logic [1:0]       cmd;
  logic             skPrev;
  logic             csPrev;
  logic             fallEdge;
  logic             csDrop;
  logic             lastAddr;
  logic [1:0]       cmdNext;

  assign fallEdge = cs & skPrev & ~sk;
  assign csDrop   = csPrev & ~cs;
  assign lastAddr = (bitCnt == addrLen - LEN_W'(1));
  assign cmdNext  = {cmd[0], di};

  always_comb begin
    strobes = '0;
    strobes.clear  = ~cs;
    strobes.commit = csDrop && (phase == PH_WDATA);
    if (fallEdge) begin
      case (phase)
        PH_ADDR: begin
          strobes.addrShift = 1'b1;
          strobes.addrDone  = lastAddr;
          strobes.fetch     = lastAddr && (cmd == CMD_READ);
        end
        PH_RDATA: strobes.rdShift = 1'b1;
        PH_WDATA: strobes.wrShift = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_WAIT;
      bitCnt <= '0;
      cmd    <= '0;
      skPrev <= 1'b0;
      csPrev <= 1'b0;
    end else begin
      skPrev <= sk;
      csPrev <= cs;
      if (!cs) begin
        phase  <= PH_WAIT;
        bitCnt <= '0;
        cmd    <= '0;
      end else if (fallEdge) begin
        case (phase)
          PH_WAIT: begin
            if (di) begin
              phase  <= PH_CMD;
              bitCnt <= '0;
            end
          end
          PH_CMD: begin
            cmd <= cmdNext;
            if (bitCnt == LEN_W'(1)) begin
              bitCnt <= '0;
              if (cmdNext == CMD_READ || cmdNext == CMD_WRITE) phase <= PH_ADDR;
              else phase <= PH_SKIP;
            end else begin
              bitCnt <= bitCnt + LEN_W'(1);
            end
          end
          PH_ADDR: begin
            if (lastAddr) begin
              bitCnt <= '0;
              phase  <= (cmd == CMD_READ) ? PH_RDATA : PH_WDATA;
            end else begin
              bitCnt <= bitCnt + LEN_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: with chip select low the decoder is parked at the start of a frame
  assert_idle_parks_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cs |=> (phase == PH_WAIT && bitCnt == '0));

  // R2: a cycle without a falling serial edge leaves the bit count alone
  assert_no_edge_no_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cs && !fallEdge) |=> $stable(bitCnt));

  // R4: at most one serial datapath action per cycle
  assert_one_action_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.addrShift, strobes.rdShift, strobes.wrShift}));

  // R10: an unsupported command never reaches the address phase
  assert_skip_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SKIP && cs) |=> (phase == PH_SKIP));

  // R8: storage happens only with chip select released
  assert_commit_on_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> !cs);

endmodule

// File: rtl/mw_eeprom_dp.sv
`timescale 1ns/1ps
module mw_eeprom_dp
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              di,
  input  ctlStrobes_t       strobes,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  output logic              dout
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrSr;
  logic [ADDR_W-1:0] addrNext;
  logic [DATA_W-1:0] rdSr;
  logic [DATA_W-1:0] wrSr;

  assign addrNext = {addrSr[ADDR_W-2:0], di};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrSr <= '0;
      rdSr   <= '0;
      wrSr   <= '0;
      dout   <= 1'b1;
    end else if (strobes.clear) begin
      addrSr <= '0;
      rdSr   <= '0;
      wrSr   <= '0;
      dout   <= 1'b1;
    end else begin
      if (strobes.addrShift) addrSr <= addrNext;
      if (strobes.addrDone) dout <= 1'b0;
      if (strobes.fetch) rdSr <= mem[addrNext];
      if (strobes.rdShift) begin
        dout <= rdSr[DATA_W-1];
        rdSr <= {rdSr[DATA_W-2:0], 1'b0};
      end
      if (strobes.wrShift) wrSr <= {wrSr[DATA_W-2:0], di};
    end
  end

  always_ff @(posedge clk) begin
    if (loadEn) mem[loadAddr] <= loadData;
    else if (strobes.commit) mem[addrSr] <= wrSr;
  end

  // R6: the last address bit is answered with a dummy zero
  assert_dummy_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.addrDone && !strobes.clear) |=> !dout);

  // R7: read data leaves the shifter most significant bit first
  assert_read_msb_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdShift && !strobes.clear) |=> (dout == $past(rdSr[DATA_W-1])));

endmodule

// File: rtl/mw_eeprom_resp.sv
`timescale 1ns/1ps
module mw_eeprom_resp
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int LEN_W = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              sk,
  input  logic              di,
  input  logic [LEN_W-1:0]  addrLen,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  output logic              dout
);

  ctlStrobes_t strobes;

  mw_eeprom_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cs      (cs),
    .sk      (sk),
    .di      (di),
    .addrLen (addrLen),
    .strobes (strobes)
  );

  mw_eeprom_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .di       (di),
    .strobes  (strobes),
    .loadEn   (loadEn),
    .loadAddr (loadAddr),
    .loadData (loadData),
    .dout     (dout)
  );

  // R1: a released chip select returns data-out to its idle level
  assert_dout_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cs |=> dout);

endmodule

// File: tb/mw_eeprom_resp_test.sv
`timescale 1ns/1ps
module mw_eeprom_resp_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cs = 1'b0;
  logic        sk = 1'b0;
  logic        di = 1'b0;
  logic [3:0]  addrLen = 4'd6;
  logic        loadEn = 1'b0;
  logic [7:0]  loadAddr = '0;
  logic [15:0] loadData = '0;
  logic        dout;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string curReq = "R1";

  logic        expDout = 1'b1;
  logic [15:0] memModel [256];
  int mPhase = 0;
  int mCnt = 0;
  int mOp = 0;
  int mAddr = 0;
  int mWord = 0;
  int mRdIdx = 0;

  always #4 clk = ~clk;

  mw_eeprom_resp uut (
    .clk(clk), .rstN(rstN), .cs(cs), .sk(sk), .di(di), .addrLen(addrLen),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData), .dout(dout)
  );

  task automatic tick();
    @(negedge clk);
    checks++;
    if (dout !== expDout) begin
      errors++;
      $display("FAIL %s: dout=%b expected %b at %0t", curReq, dout, expDout, $time);
    end
  endtask

  task automatic modelReset();
    mPhase = 0; mCnt = 0; mOp = 0; mAddr = 0; mWord = 0; mRdIdx = 0;
  endtask

  // behavioural model of one falling serial edge
  task automatic modelFall(input logic b);
    case (mPhase)
      0: if (b) begin mPhase = 1; mCnt = 0; end
      1: begin
        mOp = mOp * 2 + int'(b);
        mCnt++;
        if (mCnt == 2) begin
          mCnt = 0;
          mPhase = (mOp == 2 || mOp == 1) ? 2 : 5;
        end
      end
      2: begin
        mAddr = mAddr * 2 + int'(b);
        mCnt++;
        if (mCnt == int'(addrLen)) begin
          expDout = 1'b0;
          mPhase = (mOp == 2) ? 3 : 4;
          mRdIdx = 0;
        end
      end
      3: begin
        expDout = (mRdIdx < 16) ? memModel[mAddr][15 - mRdIdx] : 1'b0;
        mRdIdx++;
      end
      4: mWord = ((mWord << 1) | int'(b)) & 16'hffff;
      default: ;
    endcase
  endtask

  task automatic serialBit(input logic b);
    sk = 1'b1; di = b;
    tick(); tick();
    sk = 1'b0;
    if (cs) modelFall(b);
    tick(); tick();
  endtask

  task automatic csOn();
    cs = 1'b1;
    tick();
  endtask

  task automatic csOff();
    cs = 1'b0; sk = 1'b0;
    if (mPhase == 4) memModel[mAddr] = mWord[15:0];
    modelReset();
    expDout = 1'b1;
    tick(); tick();
  endtask

  task automatic sendVal(input int v, input int n);
    for (int i = n - 1; i >= 0; i--) serialBit(v[i]);
  endtask

  task automatic loadWord(input int a, input logic [15:0] d);
    loadEn = 1'b1; loadAddr = a[7:0]; loadData = d;
    memModel[a] = d;
    tick();
    loadEn = 1'b0;
  endtask

  task automatic readWord(input int a, input int extraDi);
    csOn();
    sendVal(1, 1);
    sendVal(2, 2);
    sendVal(a, int'(addrLen));
    for (int i = 0; i < 18; i++) serialBit(extraDi[i % 2]);
    csOff();
  endtask

  task automatic writeWord(input int a, input int d);
    csOn();
    sendVal(1, 1);
    sendVal(1, 2);
    sendVal(a, int'(addrLen));
    sendVal(d, 16);
    csOff();
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) memModel[i] = 16'h0000;
    curReq = "R1";
    tick();
    rstN = 1'b1;
    tick(); tick();  // R1: idle level after reset

    curReq = "R11";  // preload through the side port
    for (int i = 0; i < 256; i++) loadWord(i, 16'(i * 16'h0101 ^ 16'h5a3c));
    loadWord(5, 16'hB38E);
    loadWord(8'hC8, 16'h7E01);

    curReq = "R2";  // sk activity with cs low changes nothing
    for (int i = 0; i < 4; i++) serialBit(1'b1);

    curReq = "R3";  // leading zeros before the start bit
    csOn();
    sendVal(0, 3);
    sendVal(1, 1);
    curReq = "R4";
    sendVal(2, 2);
    curReq = "R5";
    sendVal(5, 6);
    curReq = "R7";  // di held at 1 during read data
    for (int i = 0; i < 18; i++) serialBit(1'b1);
    curReq = "R1";
    csOff();

    curReq = "R7";
    readWord(5, 2);
    readWord(8'h2A, 1);

    curReq = "R8";  // write then read back
    writeWord(9, 16'hA5C3);
    curReq = "R6";
    readWord(9, 0);

    curReq = "R9";  // abort inside the address field stores nothing
    csOn();
    sendVal(1, 1); sendVal(1, 2); sendVal(3, 4);
    csOff();
    readWord(9, 0);
    curReq = "R9";  // abort inside read data, then a fresh read
    csOn();
    sendVal(1, 1); sendVal(2, 2); sendVal(5, 6); sendVal(0, 5);
    csOff();
    readWord(5, 0);

    curReq = "R10";  // unsupported commands ignore the rest
    csOn();
    sendVal(1, 1); sendVal(3, 2); sendVal(16'h0F55, 16);
    csOff();
    csOn();
    sendVal(1, 1); sendVal(0, 2); sendVal(16'h3C09, 16);
    csOff();
    readWord(9, 0);

    curReq = "R5";  // eight-bit address
    addrLen = 4'd8;
    tick();
    readWord(8'hC8, 0);
    curReq = "R8";
    writeWord(8'hF1, 16'h1234);
    readWord(8'hF1, 1);

    curReq = "R11";  // side load overrides a written word
    loadWord(8'hF1, 16'hCAFE);
    readWord(8'hF1, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule